// File: doc/BRIEF.md
# Three-Source Vectored Interrupt Controller

This block arbitrates interrupts for a small 8-bit processor core. It takes three request sources: an external pin and overflow pulses from two timers. Each source has an enable bit and a pending flag. There is also a global enable. All of these live in one 8-bit control/status register, which the core reads and writes at a data-memory address.

Once per instruction cycle the core pulses a sampling strobe. At that strobe the block looks at every source that is both flagged and enabled. If the global enable is set and the core's stack has room, the block takes the highest-priority such source. It then raises a one-cycle call request that carries a fixed vector address. In the same step it clears that source's flag and the global enable. A return-from-interrupt strobe from the core turns the global enable back on. A plain return strobe leaves it as it is.

Requests that arrive between two strobes wait for the next strobe. Masked requests stay pending until software enables them or clears them.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the register reads 0x00, call_req is 0 and call_vec is 0x00. bus_rdata shows the register only while bus_addr equals 0x0B and is 0x00 at any other address.
- R2: Register layout: bit0 global enable, bit1 external enable, bit2 timer-0 enable, bit3 timer-1 enable, bit4 external flag, bit5 timer-0 flag, bit6 timer-1 flag. Bit7 always reads 0. A write with bus_we high at address 0x0B loads bits 6..0 on the next rising edge. A write to any other address changes nothing.
- R3: A one-cycle pulse on tmr0_ovf sets bit5, and one on tmr1_ovf sets bit6. The bit is readable after that clock edge.
- R4: A falling edge on ext_pin passes through two synchronizing flops and then sets bit4. The flag is readable after the third rising edge that follows the pin change, and not after the second.
- R5: A request is accepted only on a clock with sample_stb high, global enable 1, stack_full 0, and at least one source with both its flag and its enable set. On the next edge call_req goes high for exactly one cycle. call_vec is 0x00 whenever call_req is low.
- R6: Among accepted candidates the external source wins, then timer-0, then timer-1. Their vectors are 0x04, 0x08 and 0x0C.
- R7: Acceptance clears the chosen source's flag and the global enable. The other flags and all source enables are left unchanged.
- R8: A reti_stb pulse sets the global enable to 1. A ret_stb pulse leaves it unchanged.
- R9: A flag stays set until its source is serviced or software writes it to 0. A flagged source whose enable is off stays pending, and it is serviced at the first strobe after the enables allow it.
- R10: A hardware flag-set event wins over a same-cycle software write of that flag. Acceptance clears the global enable even if a software write or a reti_stb tries to set it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Asynchronous external request pin, active on its falling edge |
| tmr0_ovf | input | 1 | Timer-0 overflow pulse |
| tmr1_ovf | input | 1 | Timer-1 overflow pulse |
| sample_stb | input | 1 | Once-per-instruction sampling strobe |
| stack_full | input | 1 | Core stack has no free entry |
| ret_stb | input | 1 | Plain return executed |
| reti_stb | input | 1 | Return-from-interrupt executed |
| bus_addr | input | 8 | Data-memory address |
| bus_we | input | 1 | Data-memory write enable |
| bus_wdata | input | 8 | Data-memory write data |
| bus_rdata | output | 8 | Register contents when addressed, else 0 |
| call_req | output | 1 | One-cycle interrupt call request |
| call_vec | output | 8 | Vector address that goes with call_req |

## Verification
The assertions take for granted that sample_stb, the timer pulses and the return strobes are synchronous to clk. They also assume that the core never drives ret_stb and reti_stb together. The bench drives every input on the falling clock edge and raises each strobe for a single cycle. It keeps the two return strobes apart. It holds ext_pin at each level for several cycles so that the synchronizer sees every edge. It reads the register only between edges, because bus_rdata is combinational.

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h0B,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_EXT = 8'h04,
  parameter logic [VEC_W-1:0] VEC_T0  = 8'h08,
  parameter logic [VEC_W-1:0] VEC_T1  = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic              tmr0_ovf,
  input  logic              tmr1_ovf,
  input  logic              sample_stb,
  input  logic              stack_full,
  input  logic              ret_stb,
  input  logic              reti_stb,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              call_req,
  output logic [VEC_W-1:0]  call_vec
);
  localparam int NSRC = 3;

  logic            gie;
  logic [NSRC-1:0] en, flag, hw_set, live, grant;
  logic [2:0]      pin_q;
  logic            ext_fall, wr, take;
  logic [VEC_W-1:0] vec_sel;
  logic            unused_wbit;

  assign unused_wbit = bus_wdata[7];

  // two-flop synchronizer plus one delay stage for edge detection
  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= 3'b111;
    else        pin_q <= {pin_q[1:0], ext_pin};
  end

  assign ext_fall = pin_q[2] & ~pin_q[1];
  assign hw_set   = {tmr1_ovf, tmr0_ovf, ext_fall};
  assign wr       = bus_we && (bus_addr == CSR_ADDR);
  assign live     = flag & en;
  assign take     = sample_stb & gie & ~stack_full & (|live);

  always_comb begin
    grant   = '0;
    vec_sel = '0;
    if (take) begin
      if (live[0])      begin grant = 3'b001; vec_sel = VEC_EXT; end
      else if (live[1]) begin grant = 3'b010; vec_sel = VEC_T0;  end
      else              begin grant = 3'b100; vec_sel = VEC_T1;  end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie      <= 1'b0;
      en       <= '0;
      flag     <= '0;
      call_req <= 1'b0;
      call_vec <= '0;
    end else begin
      call_req <= take;
      call_vec <= vec_sel;
      if (take)          gie <= 1'b0;
      else if (reti_stb) gie <= 1'b1;
      else if (wr)       gie <= bus_wdata[0];
      if (wr) en <= bus_wdata[3:1];
      for (int i = 0; i < NSRC; i++) begin
        if (hw_set[i])     flag[i] <= 1'b1;
        else if (grant[i]) flag[i] <= 1'b0;
        else if (wr)       flag[i] <= bus_wdata[4+i];
      end
    end
  end

  assign bus_rdata = (bus_addr == CSR_ADDR) ? {1'b0, flag, en, gie} : 8'h00;

  // R5
  accept_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> ($past(sample_stb) && $past(gie) && !$past(stack_full)));

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> !call_req);

  // R5
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !call_req |-> (call_vec == '0));

  // R6
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (call_vec == VEC_EXT || call_vec == VEC_T0 || call_vec == VEC_T1));

  // R6
  prio_t0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && call_vec == VEC_T0) |-> !$past(flag[0] & en[0]));

  // R6
  prio_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && call_vec == VEC_T1) |-> !$past(live[0] | live[1]));

  // R7
  gie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !gie);

  // R8
  reti_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_stb && !take) |=> gie);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[1] && !wr && !grant[1]) |=> flag[1]);

  // R10
  hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr1_ovf |=> flag[2]);
endmodule

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;
  logic clk = 0, rst_n = 0;
  logic ext_pin = 1, tmr0_ovf = 0, tmr1_ovf = 0, sample_stb = 0, stack_full = 0;
  logic ret_stb = 0, reti_stb = 0, bus_we = 0;
  logic [7:0] bus_addr = 8'h0B, bus_wdata = 0;
  logic [7:0] bus_rdata, call_vec;
  logic call_req;
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string exp_tag[$];

  always #10 clk = ~clk;

  irq_vec_ctrl i_irq_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr0_ovf(tmr0_ovf),
    .tmr1_ovf(tmr1_ovf), .sample_stb(sample_stb), .stack_full(stack_full),
    .ret_stb(ret_stb), .reti_stb(reti_stb), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .call_req(call_req),
    .call_vec(call_vec));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // monitor: pops expected vectors as call requests appear
  always @(negedge clk) if (rst_n && call_req) begin
    if (exp_q.size() == 0) chk("R5 unexpected call", call_vec, 8'hFF);
    else chk(exp_tag.pop_front(), call_vec, exp_q.pop_front());
  end

  task automatic expect_call(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    exp_tag.push_back(tag);
  endtask

  task automatic rd(input string req, input logic [7:0] exp, input logic [7:0] a = 8'h0B);
    bus_addr = a; #1;
    chk(req, bus_rdata, exp);
    bus_addr = 8'h0B;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0; bus_addr = 8'h0B;
  endtask

  task automatic strobe();
    sample_stb = 1; @(negedge clk); sample_stb = 0;
    @(negedge clk);
  endtask

  task automatic pulse_t0(); tmr0_ovf = 1; @(negedge clk); tmr0_ovf = 0; endtask
  task automatic pulse_t1(); tmr1_ovf = 1; @(negedge clk); tmr1_ovf = 0; endtask
  task automatic do_reti();  reti_stb = 1; @(negedge clk); reti_stb = 0; endtask

  task automatic ext_fall();
    ext_pin = 0;
    repeat (3) @(negedge clk);
    ext_pin = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd("R1 reset value", 8'h00);
    chk("R1 call_req idle", {7'd0, call_req}, 8'h00);
    chk("R1 call_vec idle", call_vec, 8'h00);

    wr(8'h0B, 8'h0F); rd("R2 enables write", 8'h0F);
    wr(8'h0B, 8'hFF); rd("R2 bit7 reads 0", 8'h7F);
    wr(8'h0C, 8'h00); rd("R2 other address ignored", 8'h7F);
    rd("R1 other address reads 0", 8'h00, 8'h0C);
    wr(8'h0B, 8'h00); rd("R2 clear", 8'h00);

    pulse_t0(); rd("R3 timer-0 flag", 8'h20);
    strobe(); rd("R9 masked flag stays", 8'h20);
    wr(8'h0B, 8'h00); pulse_t1(); rd("R3 timer-1 flag", 8'h40);
    wr(8'h0B, 8'h00);

    ext_pin = 0;
    @(negedge clk); @(negedge clk);
    rd("R4 not yet after two edges", 8'h00);
    @(negedge clk);
    rd("R4 ext flag after three edges", 8'h10);
    ext_pin = 1; repeat (3) @(negedge clk);
    wr(8'h0B, 8'h00);

    wr(8'h0B, 8'h25);
    stack_full = 1; strobe(); stack_full = 0;
    rd("R5 stack full blocks", 8'h25);
    expect_call(8'h08, "R5 accept timer-0");
    strobe();
    rd("R7 flag and gie cleared", 8'h04);

    do_reti(); rd("R8 reti sets gie", 8'h05);
    wr(8'h0B, 8'h04);
    ret_stb = 1; @(negedge clk); ret_stb = 0;
    rd("R8 ret leaves gie", 8'h04);

    wr(8'h0B, 8'h0F);
    pulse_t0(); pulse_t1(); ext_fall();
    rd("R6 all pending", 8'h7F);
    expect_call(8'h04, "R6 external first");
    strobe(); rd("R7 only external cleared", 8'h6E);
    do_reti();
    expect_call(8'h08, "R6 timer-0 second");
    strobe(); rd("R7 timer-0 cleared", 8'h4E);
    do_reti();
    expect_call(8'h0C, "R6 timer-1 third");
    strobe(); rd("R7 timer-1 cleared", 8'h0E);

    wr(8'h0B, 8'h01); pulse_t1(); rd("R9 masked pending", 8'h41);
    strobe(); rd("R9 still pending", 8'h41);
    wr(8'h0B, 8'h49);
    expect_call(8'h0C, "R9 serviced once enabled");
    strobe(); rd("R9 cleared after service", 8'h08);

    wr(8'h0B, 8'h00);
    tmr0_ovf = 1; wr(8'h0B, 8'h00); tmr0_ovf = 0;
    rd("R10 hardware set beats write", 8'h20);
    wr(8'h0B, 8'h25);
    expect_call(8'h08, "R10 accept with write");
    sample_stb = 1; reti_stb = 1; wr(8'h0B, 8'h25);
    sample_stb = 0; reti_stb = 0;
    @(negedge clk);
    rd("R10 acceptance beats write", 8'h04);

    repeat (3) @(negedge clk);
    chk("R5 all expected calls seen", 8'(exp_q.size()), 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule